// File: doc/BRIEF.md
# SIMT Lane Divergence Mask Stack

This block tracks which lanes of a single SIMD thread are active while that thread runs nested conditional code, and it chooses whether the next PC is sequential or a jump. It holds a current active-lane mask in a register. A small stack holds saved masks, each tagged with a reconvergence address and an entry kind. Every cycle the issue stage presents one encoded command, a per-lane condition vector, a jump target and a reconvergence address. The block answers in the same cycle with a PC select, a target, and flags for unanimous outcomes, overflow and underflow. The mask and the stack change on the next clock edge.

A conditional branch splits the active lanes only when they disagree. In that case the prior mask is saved with the IF's reconvergence address. When all active lanes agree, nothing is saved and the unneeded path is skipped. The ELSE and end-of-IF markers carry the same reconvergence address. The block compares it with the top entry, so it can tell an IF that diverged from one that did not, even when IFs are nested. Indexed jumps and calls save the mask so the lanes can reconverge later, and a converge command restores the saved mask and address.

Top module: `simt_mask_stack`

## Requirements
- R1: After synchronous reset the active mask is all ones, the stack depth is 0, and every flag and pc_sel are 0.
- R2: Command BRA (cmd=1), with taken = cond & active mask neither zero nor equal to the mask and the stack not full: the old mask is pushed with rcv_pc as kind DIV, the mask becomes taken, depth rises by 1, and pc_sel=0.
- R3: BRA with taken equal to the active mask and nonzero: uni_taken=1, pc_sel=0, and the mask and depth do not change.
- R4: BRA with taken zero, including when the mask itself is zero: uni_skip=1, pc_sel=1, pc_tgt=tgt_pc, and the mask and depth do not change.
- R5: ELSE (cmd=2) when the top entry is kind DIV and its address equals rcv_pc: the new mask is the saved mask ANDed with the inverse of the current mask, the entry is retagged as kind ELSE, depth is unchanged, and pc_sel=0.
- R6: ELSE in any other case: pc_sel=1 and pc_tgt=tgt_pc, which skips the ELSE body; the mask and depth do not change.
- R7: SYNC (cmd=3) when the top entry's address equals rcv_pc and its kind is DIV or ELSE: the entry is popped and the mask restored from it. In any other case SYNC changes nothing. pc_sel=0 in both cases.
- R8: IJMP (cmd=4) with the stack not full: the current mask is pushed with rcv_pc as kind CALL, pc_sel=1, pc_tgt=tgt_pc, and the mask does not change.
- R9: CONV (cmd=5) with a non-empty stack: the top entry is popped, the mask takes its saved value, pc_sel=1, and pc_tgt is the saved address (last pushed, first restored).
- R10: A BRA that would diverge, or an IJMP, while the depth equals DEPTH (8): ovf=1, pc_sel=0, and the mask and stack do not change.
- R11: CONV with an empty stack: unf=1, pc_sel=0, and nothing changes.
- R12: NOP (cmd=0, and codes 6 and 7): all flags and pc_sel are 0, pc_tgt is 0, and the state does not change. pc_tgt is 0 whenever pc_sel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command code: 0 NOP, 1 BRA, 2 ELSE, 3 SYNC, 4 IJMP, 5 CONV |
| cond | input | LANES | Per-lane branch condition |
| tgt_pc | input | PC_W | Jump target for skip, ELSE-skip and indexed jump |
| rcv_pc | input | PC_W | Reconvergence address, pushed or compared with the top entry |
| act_mask | output | LANES | Current active-lane mask |
| pc_sel | output | 1 | 1 selects pc_tgt as the next PC |
| pc_tgt | output | PC_W | Next-PC target, 0 when pc_sel is 0 |
| uni_taken | output | 1 | All active lanes take the THEN path |
| uni_skip | output | 1 | No active lane takes the THEN path |
| ovf | output | 1 | Push refused because the stack is full |
| unf | output | 1 | Converge refused because the stack is empty |
| stk_depth | output | $clog2(DEPTH+1) | Number of stack entries |

## Verification
The hardest state to reach is a full stack of eight entries. Each divergent branch shrinks the mask, so a random branch stream splits a 32-lane mask only a few times before the branches turn unanimous. The stimulus fills the stack with indexed jumps, which do not shrink the mask, then offers one more jump and a divergent branch to check that overflow leaves the state untouched. It then unwinds the stack with converges to check the stored addresses in reverse order. In the random phase, ELSE and SYNC usually carry the top entry's own address so that matched markers occur often, mixed with mismatched ones that must skip or do nothing.

// File: rtl/simt_stk_pkg.sv
package simt_stk_pkg;

    typedef enum logic [2:0] {
        C_NOP  = 3'd0,
        C_BRA  = 3'd1,
        C_ELSE = 3'd2,
        C_SYNC = 3'd3,
        C_IJMP = 3'd4,
        C_CONV = 3'd5
    } cmd_e;

    typedef enum logic [1:0] {
        K_DIV  = 2'd0,
        K_ELS  = 2'd1,
        K_CALL = 2'd2
    } kind_e;

    // width-independent control decision produced by the controller
    typedef struct packed {
        logic push;
        logic pop;
        logic retag;
        logic act_we;
        logic pc_sel;
        logic uni_t;
        logic uni_n;
        logic ovf;
        logic unf;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{default: 1'b0};

endpackage

// File: rtl/mask_stack.sv
module mask_stack
    import simt_stk_pkg::*;
#(
    parameter int LANES = 32,
    parameter int PC_W  = 32,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic                         pop,
    input  logic                         retag,
    input  logic [LANES-1:0]             in_mask,
    input  logic [PC_W-1:0]              in_addr,
    input  kind_e                        in_kind,
    output logic [LANES-1:0]             top_mask,
    output logic [PC_W-1:0]              top_addr,
    output kind_e                        top_kind,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int IW = $clog2(DEPTH);

    logic [LANES-1:0] m_q [DEPTH];
    logic [PC_W-1:0]  a_q [DEPTH];
    kind_e            k_q [DEPTH];
    logic [CW-1:0]    cnt_q;
    logic [IW-1:0]    top_idx;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign count   = cnt_q;
    assign top_idx = IW'(cnt_q - CW'(1));

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                m_q[g] <= '0;
                a_q[g] <= '0;
                k_q[g] <= K_DIV;
            end else if (push && !full && cnt_q == CW'(g)) begin
                m_q[g] <= in_mask;
                a_q[g] <= in_addr;
                k_q[g] <= in_kind;
            end else if (retag && cnt_q == CW'(g + 1)) begin
                k_q[g] <= K_ELS;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (push && !full)
            cnt_q <= cnt_q + CW'(1);
        else if (pop && !empty)
            cnt_q <= cnt_q - CW'(1);
    end

    always_comb begin
        if (empty) begin
            top_mask = '0;
            top_addr = '0;
            top_kind = K_DIV;
        end else begin
            top_mask = m_q[top_idx];
            top_addr = a_q[top_idx];
            top_kind = k_q[top_idx];
        end
    end

    AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);  // R10
    AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);  // R11
    AST_RETAG_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        retag |=> (cnt_q == $past(cnt_q)));  // R5

endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
    import simt_stk_pkg::*;
#(
    parameter int LANES = 32,
    parameter int PC_W  = 32
) (
    input  logic [2:0]        cmd,
    input  logic [LANES-1:0]  cond,
    input  logic [PC_W-1:0]   tgt_pc,
    input  logic [PC_W-1:0]   rcv_pc,
    input  logic [LANES-1:0]  act,
    input  logic [LANES-1:0]  top_mask,
    input  logic [PC_W-1:0]   top_addr,
    input  kind_e             top_kind,
    input  logic              empty,
    input  logic              full,
    output ctl_t              ctl,
    output logic [LANES-1:0]  nxt_act,
    output logic [PC_W-1:0]   pc_tgt,
    output logic [LANES-1:0]  psh_mask,
    output logic [PC_W-1:0]   psh_addr,
    output kind_e             psh_kind
);
    logic [LANES-1:0] taken;
    logic             top_hit;

    assign taken    = cond & act;
    assign top_hit  = !empty && (top_addr == rcv_pc);
    assign psh_mask = act;
    assign psh_addr = rcv_pc;

    always_comb begin
        ctl      = CTL_IDLE;
        nxt_act  = act;
        pc_tgt   = '0;
        psh_kind = K_DIV;
        case (cmd)
            C_BRA: begin
                if (taken == '0) begin
                    ctl.uni_n  = 1'b1;
                    ctl.pc_sel = 1'b1;
                    pc_tgt     = tgt_pc;
                end else if (taken == act) begin
                    ctl.uni_t = 1'b1;
                end else if (full) begin
                    ctl.ovf = 1'b1;
                end else begin
                    ctl.push   = 1'b1;
                    ctl.act_we = 1'b1;
                    nxt_act    = taken;
                end
            end
            C_ELSE: begin
                if (top_hit && top_kind == K_DIV) begin
                    ctl.retag  = 1'b1;
                    ctl.act_we = 1'b1;
                    nxt_act    = top_mask & ~act;
                end else begin
                    ctl.pc_sel = 1'b1;
                    pc_tgt     = tgt_pc;
                end
            end
            C_SYNC: begin
                if (top_hit && top_kind != K_CALL) begin
                    ctl.pop    = 1'b1;
                    ctl.act_we = 1'b1;
                    nxt_act    = top_mask;
                end
            end
            C_IJMP: begin
                if (full) begin
                    ctl.ovf = 1'b1;
                end else begin
                    ctl.push   = 1'b1;
                    ctl.pc_sel = 1'b1;
                    pc_tgt     = tgt_pc;
                    psh_kind   = K_CALL;
                end
            end
            C_CONV: begin
                if (empty) begin
                    ctl.unf = 1'b1;
                end else begin
                    ctl.pop    = 1'b1;
                    ctl.act_we = 1'b1;
                    ctl.pc_sel = 1'b1;
                    nxt_act    = top_mask;
                    pc_tgt     = top_addr;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
    import simt_stk_pkg::*;
#(
    parameter int LANES = 32,
    parameter int PC_W  = 32,
    parameter int DEPTH = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [2:0]                  cmd,
    input  logic [LANES-1:0]            cond,
    input  logic [PC_W-1:0]             tgt_pc,
    input  logic [PC_W-1:0]             rcv_pc,
    output logic [LANES-1:0]            act_mask,
    output logic                        pc_sel,
    output logic [PC_W-1:0]             pc_tgt,
    output logic                        uni_taken,
    output logic                        uni_skip,
    output logic                        ovf,
    output logic                        unf,
    output logic [$clog2(DEPTH+1)-1:0]  stk_depth
);
    localparam int CW = $clog2(DEPTH+1);

    ctl_t             ctl;
    logic [LANES-1:0] act_q;
    logic [LANES-1:0] nxt_act;
    logic [LANES-1:0] top_mask;
    logic [PC_W-1:0]  top_addr;
    kind_e            top_kind;
    logic [LANES-1:0] psh_mask;
    logic [PC_W-1:0]  psh_addr;
    kind_e            psh_kind;
    logic             st_full;
    logic             st_empty;
    logic [CW-1:0]    st_cnt;

    div_ctrl #(.LANES(LANES), .PC_W(PC_W)) ctrl_i (
        .cmd      (cmd),
        .cond     (cond),
        .tgt_pc   (tgt_pc),
        .rcv_pc   (rcv_pc),
        .act      (act_q),
        .top_mask (top_mask),
        .top_addr (top_addr),
        .top_kind (top_kind),
        .empty    (st_empty),
        .full     (st_full),
        .ctl      (ctl),
        .nxt_act  (nxt_act),
        .pc_tgt   (pc_tgt),
        .psh_mask (psh_mask),
        .psh_addr (psh_addr),
        .psh_kind (psh_kind)
    );

    mask_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) stk_i (
        .clk      (clk),
        .rst      (rst),
        .push     (ctl.push),
        .pop      (ctl.pop),
        .retag    (ctl.retag),
        .in_mask  (psh_mask),
        .in_addr  (psh_addr),
        .in_kind  (psh_kind),
        .top_mask (top_mask),
        .top_addr (top_addr),
        .top_kind (top_kind),
        .count    (st_cnt),
        .full     (st_full),
        .empty    (st_empty)
    );

    always_ff @(posedge clk) begin
        if (rst)
            act_q <= '1;
        else if (ctl.act_we)
            act_q <= nxt_act;
    end

    assign act_mask  = act_q;
    assign stk_depth = st_cnt;
    assign pc_sel    = ctl.pc_sel;
    assign uni_taken = ctl.uni_t;
    assign uni_skip  = ctl.uni_n;
    assign ovf       = ctl.ovf;
    assign unf       = ctl.unf;

    AST_DIV_SUBSET: assert property (@(posedge clk) disable iff (rst)
        (cmd == C_BRA && !uni_taken && !uni_skip && !ovf)
        |=> ((act_mask & ~$past(act_mask)) == '0) && (stk_depth == $past(stk_depth) + CW'(1)));  // R2
    AST_UNI_HOLD: assert property (@(posedge clk) disable iff (rst)
        (uni_taken || uni_skip) |=> $stable(act_mask) && $stable(stk_depth));  // R3
    AST_SKIP_JUMPS: assert property (@(posedge clk) disable iff (rst)
        uni_skip |-> pc_sel && (pc_tgt == tgt_pc));  // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        ovf |=> $stable(act_mask) && $stable(stk_depth));  // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        unf |=> $stable(act_mask) && (stk_depth == '0));  // R11
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({uni_taken, uni_skip, ovf, unf}));  // R12
    AST_TGT_ZERO: assert property (@(posedge clk) disable iff (rst)
        !pc_sel |-> (pc_tgt == '0));  // R12

endmodule

// File: tb/simt_mask_stack_tb.sv
`timescale 1ns/1ps
module simt_mask_stack_tb_top;

    localparam int LANES = 32;
    localparam int PC_W  = 32;
    localparam int DEPTH = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [2:0]        cmd = 3'd0;
    logic [LANES-1:0]  cond = '0;
    logic [PC_W-1:0]   tgt_pc = '0;
    logic [PC_W-1:0]   rcv_pc = '0;
    logic [LANES-1:0]  act_mask;
    logic              pc_sel;
    logic [PC_W-1:0]   pc_tgt;
    logic              uni_taken, uni_skip, ovf, unf;
    logic [3:0]        stk_depth;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // reference state
    logic [LANES-1:0] rm [DEPTH];
    logic [PC_W-1:0]  ra [DEPTH];
    int               rk [DEPTH];   // 0 DIV, 1 ELSE, 2 CALL
    int               rd;
    logic [LANES-1:0] ract;

    always #2.5 clk = ~clk;

    simt_mask_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .cmd(cmd), .cond(cond), .tgt_pc(tgt_pc), .rcv_pc(rcv_pc),
        .act_mask(act_mask), .pc_sel(pc_sel), .pc_tgt(pc_tgt), .uni_taken(uni_taken),
        .uni_skip(uni_skip), .ovf(ovf), .unf(unf), .stk_depth(stk_depth)
    );

    task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // one command: drive at a falling edge, check decision, then check state after the rising edge
    task automatic step(input logic [2:0] c, input logic [31:0] cv, input logic [31:0] t, input logic [31:0] r);
        logic [LANES-1:0] tk;
        logic [LANES-1:0] n_act;
        logic             e_sel, e_ut, e_un, e_ov, e_uf;
        logic [PC_W-1:0]  e_tgt;
        string            req;
        cmd = c; cond = cv; tgt_pc = t; rcv_pc = r;
        #1;
        tk = cv & ract;
        n_act = ract;
        e_sel = 0; e_ut = 0; e_un = 0; e_ov = 0; e_uf = 0; e_tgt = '0;
        req = "R12";
        case (c)
            3'd1: begin
                if (tk == '0) begin e_un = 1; e_sel = 1; e_tgt = t; req = "R4"; end
                else if (tk == ract) begin e_ut = 1; req = "R3"; end
                else if (rd == DEPTH) begin e_ov = 1; req = "R10"; end
                else begin rm[rd] = ract; ra[rd] = r; rk[rd] = 0; rd++; n_act = tk; req = "R2"; end
            end
            3'd2: begin
                if (rd > 0 && ra[rd-1] == r && rk[rd-1] == 0) begin
                    n_act = rm[rd-1] & ~ract; rk[rd-1] = 1; req = "R5";
                end else begin e_sel = 1; e_tgt = t; req = "R6"; end
            end
            3'd3: begin
                req = "R7";
                if (rd > 0 && ra[rd-1] == r && rk[rd-1] != 2) begin n_act = rm[rd-1]; rd--; end
            end
            3'd4: begin
                if (rd == DEPTH) begin e_ov = 1; req = "R10"; end
                else begin rm[rd] = ract; ra[rd] = r; rk[rd] = 2; rd++; e_sel = 1; e_tgt = t; req = "R8"; end
            end
            3'd5: begin
                if (rd == 0) begin e_uf = 1; req = "R11"; end
                else begin n_act = rm[rd-1]; e_sel = 1; e_tgt = ra[rd-1]; rd--; req = "R9"; end
            end
            default: req = "R12";
        endcase
        chk(req, "pc_sel", 64'(pc_sel), 64'(e_sel));
        chk(req, "pc_tgt", 64'(pc_tgt), 64'(e_tgt));
        chk(req, "flags{ut,us,ov,uf}", 64'({uni_taken, uni_skip, ovf, unf}), 64'({e_ut, e_un, e_ov, e_uf}));
        ract = n_act;
        @(negedge clk);
        chk(req, "act_mask", 64'(act_mask), 64'(ract));
        chk(req, "stk_depth", 64'(stk_depth), 64'(rd));
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [2:0]  c;
        logic [31:0] cv, r;
        int          sel;
        void'($urandom(32'd2024));
        rd = 0; ract = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1", "act_mask", 64'(act_mask), 64'hFFFF_FFFF);
        chk("R1", "stk_depth", 64'(stk_depth), 64'd0);
        chk("R1", "flags+sel", 64'({pc_sel, uni_taken, uni_skip, ovf, unf}), 64'd0);
        @(negedge clk);

        step(3'd0, 32'h1234_5678, 32'h40, 32'h44);   // R12 NOP
        step(3'd7, 32'hFFFF_FFFF, 32'h40, 32'h44);   // R12 unused code
        step(3'd1, 32'h0, 32'h80, 32'h100);          // R4 all false
        step(3'd1, 32'hFFFF_FFFF, 32'h80, 32'h100);  // R3 all true
        step(3'd1, 32'h0000_FFFF, 32'h80, 32'h100);  // R2 diverge
        step(3'd1, 32'hF0F0_00FF, 32'h88, 32'h90);   // R2 nested
        step(3'd2, 32'h0, 32'h8C, 32'h90);           // R5 flip
        step(3'd2, 32'h0, 32'h8C, 32'h90);           // R6 already flipped
        step(3'd3, 32'h0, 32'h0, 32'h90);            // R7 pop nested
        step(3'd3, 32'h0, 32'h0, 32'h55);            // R7 mismatch
        step(3'd1, 32'hFFFF_FFFF, 32'h80, 32'h200);  // R3 under partial mask
        step(3'd2, 32'h0, 32'hA0, 32'h200);          // R6 unanimous IF skip
        step(3'd3, 32'h0, 32'h0, 32'h100);           // R7 no-else restore
        step(3'd5, 32'h0, 32'h0, 32'h0);             // R11 underflow
        for (int i = 0; i < DEPTH; i++)
            step(3'd4, 32'h0, 32'h1000 + 32'(i), 32'h2000 + 32'(4*i));  // R8
        step(3'd4, 32'h0, 32'h3000, 32'h3004);       // R10 full
        step(3'd1, 32'h0000_0001, 32'h3008, 32'h300C); // R10 divergent at full
        step(3'd3, 32'h0, 32'h0, 32'h201C);          // R7 CALL entry not popped by SYNC
        for (int i = 0; i < DEPTH; i++)
            step(3'd5, 32'h0, 32'h0, 32'h0);         // R9 unwind in reverse
        step(3'd5, 32'h0, 32'h0, 32'h0);             // R11

        // constrained random phase
        for (int n = 0; n < 4000; n++) begin
            sel = int'($urandom % 16);
            if (sel == 0) c = 3'd0;
            else if (sel <= 5) c = 3'd1;
            else if (sel <= 8) c = 3'd2;
            else if (sel <= 11) c = 3'd3;
            else if (sel <= 13) c = 3'd4;
            else c = 3'd5;
            case ($urandom % 4)
                0: cv = 32'h0;
                1: cv = 32'hFFFF_FFFF;
                default: cv = $urandom;
            endcase
            if ((c == 3'd2 || c == 3'd3) && rd > 0 && ($urandom % 4) != 0)
                r = ra[rd-1];
            else
                r = ($urandom % 64) * 4;
            step(c, cv, ($urandom % 256) * 4, r);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule